// File: doc/BRIEF.md
# Debug Pin-Mux Mode Register

This block is an 8-bit control register that decides how five dedicated pins are used. When its single active bit is 0, the pins are ordinary port or alternate-function pins, and the port logic sets their directions. When the bit is 1, the pins carry a debug interface. That interface has five lines: a debug reset input, a data input, a data output, a clock input and a mode-select input. In debug mode the block forces the pin directions itself and raises a per-pin mux select. The port logic's direction settings then have no effect on those pins.

Software reaches the register through a small bus port at a fixed offset. The port supports whole-byte writes, single-bit set and single-bit clear, and reads. A change to debug mode is accepted only while the debug reset pin is high. Three reset sources act on the bit in different ways:

- A power-on-clear reset forces normal mode.
- An external reset forces debug mode.
- Any other reset leaves the bit as it was.

The control bit is held by a two-state machine with states `MODE_PORT` and `MODE_DEBUG`. Its transitions are:

- `ENTER`: a qualified set moves `MODE_PORT` to `MODE_DEBUG`.
- `LEAVE`: a clear moves `MODE_DEBUG` to `MODE_PORT`.
- `POR_FORCE`: any state goes to `MODE_PORT`.
- `EXT_FORCE`: any state goes to `MODE_DEBUG`.
- `HOLD`: under another reset, or with no qualified write, the state stays as it is.

Top module: `pmx_dbg_mode_reg`

## Requirements
- R1: The register is decoded at offset 0xFC. A read (`bus_sel`=1, `bus_wr`=0, matching address) returns the mode bit in bit 0 and zeros in bits 7..1. A read at any other address, and any cycle without a read, returns 0 on `bus_rdata`.
- R2: A byte write (`bus_op`=00) to the offset with `bus_be`=1 loads `bus_wdata[0]` into the mode bit, taking effect after the clock edge. A write with `bus_be`=0, or to another offset, leaves the bit unchanged.
- R3: A bit-set (`bus_op`=01) or bit-clear (`bus_op`=10) with `bus_bitpos`=0 sets or clears the mode bit. With any other bit position, or with `bus_op`=11, the bit is unchanged.
- R4: A write that would change the bit from 0 to 1 takes effect only if `dbg_rst_lvl` is 1 in that cycle; otherwise the bit stays 0. A write of 0 always takes effect.
- R5: `por_req` at a clock edge forces the bit to 0. It overrides every other reset and any write.
- R6: `ext_req` without `por_req` forces the bit to 1 and overrides the other resets and any write.
- R7: `oth_req` alone keeps the bit at its value from before the reset.
- R8: Bus writes in a cycle with any reset request have no effect beyond the reset itself.
- R9: In debug mode, `pin_dir` is 5'b00100 (pin order 0 debug reset, 1 data in, 2 data out, 3 clock, 4 mode select; 1 = output). `pin_dbg_sel` is all ones, and `port_dir` has no effect.
- R10: In normal mode, `pin_dir` equals `port_dir` and `pin_dbg_sel` is 0. `dbg_mode` always shows the mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on-clear reset request |
| ext_req | input | 1 | External pin reset request |
| oth_req | input | 1 | Any other reset request |
| dbg_rst_lvl | input | 1 | Level of the debug reset pin |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_be | input | 1 | Byte-lane write enable |
| bus_op | input | 2 | 00 byte, 01 bit set, 10 bit clear, 11 none |
| bus_wdata | input | 8 | Write data |
| bus_bitpos | input | 3 | Bit index for set or clear |
| bus_rdata | output | 8 | Read data |
| port_dir | input | 5 | Directions requested by the port logic |
| pin_dir | output | 5 | Resulting pin directions |
| pin_dbg_sel | output | 5 | Per-pin debug mux select |
| dbg_mode | output | 1 | Current mode bit |

## Verification
The bench goes after several corner cases, each tied to a specific failure:

- **Set while the debug reset pin is low.** A design that skipped the qualification would enter debug mode.
- **Clear while the pin is low.** A design that gated every write on the pin would stick in debug mode.
- **Reset requests in the same cycle as each other and as writes.** A wrong priority order leaves the wrong bit value. Letting a write win over a reset shows up as a change under `oth_req`.
- **Bit operations with a nonzero bit position, and writes with the lane disabled.** A careless decoder would disturb the mode bit.
- **Randomised `port_dir` while in debug mode.** It exposes any leak of port settings into the forced directions.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
    typedef enum logic [1:0] {
        RST_NONE  = 2'd0,
        RST_POR   = 2'd1,
        RST_EXT   = 2'd2,
        RST_OTHER = 2'd3
    } rst_kind_e;

    typedef enum logic [1:0] {
        OP_BYTE = 2'b00,
        OP_BSET = 2'b01,
        OP_BCLR = 2'b10,
        OP_NONE = 2'b11
    } bus_op_e;

    typedef enum logic {
        MODE_PORT  = 1'b0,
        MODE_DEBUG = 1'b1
    } mode_e;
endpackage

// File: rtl/pmx_rst_arb.sv
module pmx_rst_arb
    import pmx_pkg::*;
(
    input  logic      por_req,
    input  logic      ext_req,
    input  logic      oth_req,
    output rst_kind_e rst_kind,
    output logic      rst_any
);
    always_comb begin
        if (por_req)      rst_kind = RST_POR;
        else if (ext_req) rst_kind = RST_EXT;
        else if (oth_req) rst_kind = RST_OTHER;
        else              rst_kind = RST_NONE;
        rst_any = (rst_kind != RST_NONE);
    end
endmodule

// File: rtl/pmx_bus_dec.sv
module pmx_bus_dec
    import pmx_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          DATA_W     = 8,
    parameter logic [7:0]  REG_OFFSET = 8'hFC,
    localparam int         BITPOS_W   = $clog2(DATA_W)
) (
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_be,
    input  logic [1:0]          bus_op,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [BITPOS_W-1:0] bus_bitpos,
    input  logic                rst_any,
    input  logic                mode_bit,
    output logic                set_req,
    output logic                clr_req,
    output logic [DATA_W-1:0]   bus_rdata
);
    logic hit;
    logic wr_ok;
    logic pos0;

    always_comb begin
        hit     = bus_sel && (bus_addr == ADDR_W'(REG_OFFSET));
        wr_ok   = hit && bus_wr && bus_be && !rst_any;
        pos0    = (bus_bitpos == '0);
        set_req = 1'b0;
        clr_req = 1'b0;
        if (wr_ok) begin
            unique case (bus_op_e'(bus_op))
                OP_BYTE: begin
                    set_req = bus_wdata[0];
                    clr_req = !bus_wdata[0];
                end
                OP_BSET: set_req = pos0;
                OP_BCLR: clr_req = pos0;
                OP_NONE: ;
            endcase
        end
        bus_rdata = (hit && !bus_wr) ? {{(DATA_W-1){1'b0}}, mode_bit} : '0;
    end
endmodule

// File: rtl/pmx_mode_fsm.sv
module pmx_mode_fsm
    import pmx_pkg::*;
(
    input  logic      clk,
    input  rst_kind_e rst_kind,
    input  logic      set_req,
    input  logic      clr_req,
    input  logic      dbg_rst_lvl,
    output logic      mode_bit
);
    mode_e state_q;
    mode_e state_d;
    logic  chk_live_q;

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (rst_kind)
            RST_POR:   state_d = MODE_PORT;   // POR_FORCE
            RST_EXT:   state_d = MODE_DEBUG;  // EXT_FORCE
            RST_OTHER: state_d = state_q;     // HOLD
            RST_NONE: begin
                unique case (state_q)
                    MODE_PORT:  if (set_req && dbg_rst_lvl) state_d = MODE_DEBUG; // ENTER
                    MODE_DEBUG: if (clr_req)                state_d = MODE_PORT;  // LEAVE
                endcase
            end
        endcase
    end

    always_comb begin
        mode_bit = (state_q == MODE_DEBUG);
    end

    always_ff @(posedge clk) begin
        if (rst_kind == RST_POR) chk_live_q <= 1'b1;
    end

    assert_por_forces_port_R5: assert property (@(posedge clk) disable iff (chk_live_q !== 1'b1)
        (rst_kind == RST_POR) |=> (mode_bit == 1'b0));
    assert_ext_forces_debug_R6: assert property (@(posedge clk) disable iff (chk_live_q !== 1'b1)
        (rst_kind == RST_EXT) |=> (mode_bit == 1'b1));
    assert_other_holds_R7: assert property (@(posedge clk) disable iff (chk_live_q !== 1'b1)
        (rst_kind == RST_OTHER) |=> $stable(mode_bit));
    assert_set_gated_R4: assert property (@(posedge clk) disable iff (chk_live_q !== 1'b1)
        (rst_kind == RST_NONE && set_req && !dbg_rst_lvl && !mode_bit) |=> !mode_bit);
    assert_clear_wins_R4: assert property (@(posedge clk) disable iff (chk_live_q !== 1'b1)
        (rst_kind == RST_NONE && clr_req) |=> !mode_bit);
endmodule

// File: rtl/pmx_pin_ovr.sv
module pmx_pin_ovr #(
    parameter int NUM_PINS = 5,
    parameter int DOUT_IDX = 2
) (
    input  logic                clk,
    input  logic                dbg_mode,
    input  logic [NUM_PINS-1:0] port_dir,
    output logic [NUM_PINS-1:0] pin_dir,
    output logic [NUM_PINS-1:0] pin_dbg_sel
);
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        localparam logic DBG_DIR = (g == DOUT_IDX);
        always_comb begin
            pin_dir[g]     = dbg_mode ? DBG_DIR : port_dir[g];
            pin_dbg_sel[g] = dbg_mode;
        end
    end

    logic chk_live_q;
    always_ff @(posedge clk) chk_live_q <= 1'b1;

    assert_debug_dir_fixed_R9: assert property (@(posedge clk) disable iff (chk_live_q !== 1'b1)
        (dbg_mode && $past(dbg_mode)) |-> $stable(pin_dir));
    assert_sel_follows_mode_R10: assert property (@(posedge clk) disable iff (chk_live_q !== 1'b1)
        !dbg_mode |-> (pin_dbg_sel == '0 && pin_dir == port_dir));
endmodule

// File: rtl/pmx_dbg_mode_reg.sv
module pmx_dbg_mode_reg
    import pmx_pkg::*;
#(
    parameter int         ADDR_W     = 8,
    parameter int         DATA_W     = 8,
    parameter logic [7:0] REG_OFFSET = 8'hFC,
    parameter int         NUM_PINS   = 5,
    parameter int         DOUT_IDX   = 2,
    localparam int        BITPOS_W   = $clog2(DATA_W)
) (
    input  logic                clk,
    input  logic                por_req,
    input  logic                ext_req,
    input  logic                oth_req,
    input  logic                dbg_rst_lvl,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_be,
    input  logic [1:0]          bus_op,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [BITPOS_W-1:0] bus_bitpos,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] port_dir,
    output logic [NUM_PINS-1:0] pin_dir,
    output logic [NUM_PINS-1:0] pin_dbg_sel,
    output logic                dbg_mode
);
    rst_kind_e rst_kind;
    logic      rst_any;
    logic      set_req;
    logic      clr_req;
    logic      mode_bit;

    pmx_rst_arb u_arb (
        .por_req (por_req),
        .ext_req (ext_req),
        .oth_req (oth_req),
        .rst_kind(rst_kind),
        .rst_any (rst_any)
    );

    pmx_bus_dec #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .REG_OFFSET(REG_OFFSET)
    ) u_dec (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_op    (bus_op),
        .bus_wdata (bus_wdata),
        .bus_bitpos(bus_bitpos),
        .rst_any   (rst_any),
        .mode_bit  (mode_bit),
        .set_req   (set_req),
        .clr_req   (clr_req),
        .bus_rdata (bus_rdata)
    );

    pmx_mode_fsm u_fsm (
        .clk        (clk),
        .rst_kind   (rst_kind),
        .set_req    (set_req),
        .clr_req    (clr_req),
        .dbg_rst_lvl(dbg_rst_lvl),
        .mode_bit   (mode_bit)
    );

    pmx_pin_ovr #(
        .NUM_PINS(NUM_PINS),
        .DOUT_IDX(DOUT_IDX)
    ) u_pin (
        .clk        (clk),
        .dbg_mode   (mode_bit),
        .port_dir   (port_dir),
        .pin_dir    (pin_dir),
        .pin_dbg_sel(pin_dbg_sel)
    );

    always_comb dbg_mode = mode_bit;

    assert_reset_blocks_write_R8: assert property (@(posedge clk) disable iff (por_req || ext_req)
        (oth_req && bus_sel && bus_wr) |=> $stable(mode_bit));
endmodule

// File: tb/pmx_dbg_mode_reg_tb_top.sv
module pmx_dbg_mode_reg_tb_top;
    logic       clk = 1'b0;
    logic       por_req = 1'b0, ext_req = 1'b0, oth_req = 1'b0, dbg_rst_lvl = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_be = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, bus_rdata;
    logic [1:0] bus_op = 2'b11;
    logic [2:0] bus_bitpos = 3'd0;
    logic [4:0] port_dir = 5'd0, pin_dir, pin_dbg_sel;
    logic       dbg_mode;

    int checks = 0;
    int errors = 0;
    logic model = 1'b0;

    always #5 clk = ~clk;

    pmx_dbg_mode_reg dut_i (
        .clk(clk), .por_req(por_req), .ext_req(ext_req), .oth_req(oth_req),
        .dbg_rst_lvl(dbg_rst_lvl), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_op(bus_op),
        .bus_wdata(bus_wdata), .bus_bitpos(bus_bitpos), .bus_rdata(bus_rdata),
        .port_dir(port_dir), .pin_dir(pin_dir), .pin_dbg_sel(pin_dbg_sel),
        .dbg_mode(dbg_mode)
    );

    function automatic logic next_mode(logic cur);
        logic want, has;
        if (por_req) return 1'b0;
        if (ext_req) return 1'b1;
        if (oth_req) return cur;
        has = 1'b0; want = cur;
        if (bus_sel && bus_wr && bus_be && bus_addr == 8'hFC) begin
            case (bus_op)
                2'b00: begin has = 1'b1; want = bus_wdata[0]; end
                2'b01: if (bus_bitpos == 3'd0) begin has = 1'b1; want = 1'b1; end
                2'b10: if (bus_bitpos == 3'd0) begin has = 1'b1; want = 1'b0; end
                default: ;
            endcase
        end
        if (!has) return cur;
        if (want && !cur && !dbg_rst_lvl) return cur;
        return want;
    endfunction

    function automatic logic [4:0] exp_dir(logic m, logic [4:0] pd);
        return m ? 5'b00100 : pd;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_outputs(string tag);
        chk({tag, " R10 mode"}, 16'(dbg_mode), 16'(model));
        chk(model ? "R9 dir" : "R10 dir", 16'(pin_dir), 16'(exp_dir(model, port_dir)));
        chk(model ? "R9 sel" : "R10 sel", 16'(pin_dbg_sel), model ? 16'h1F : 16'h0);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'hFC;
        #1 chk("R1 read", 16'(bus_rdata), 16'(model));
        bus_addr = 8'hF8;
        #1 chk("R1 other addr", 16'(bus_rdata), 16'h0);
        bus_sel = 1'b0;
    endtask

    task automatic step(logic p, logic e, logic o, logic lvl, logic sel, logic wr,
                        logic [7:0] a, logic be, logic [1:0] op, logic [7:0] wd,
                        logic [2:0] bp, logic [4:0] pd, string tag);
        por_req = p; ext_req = e; oth_req = o; dbg_rst_lvl = lvl;
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_be = be; bus_op = op;
        bus_wdata = wd; bus_bitpos = bp; port_dir = pd;
        model = next_mode(model);
        @(posedge clk);
        @(negedge clk);
        por_req = 1'b0; ext_req = 1'b0; oth_req = 1'b0; bus_wr = 1'b0;
        check_outputs(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        step(1,0,0,0, 0,0,8'hFC,0,2'b11,0,0,5'h0A, "R5 por");
        step(0,0,0,0, 1,1,8'hFC,1,2'b00,8'h01,0,5'h0A, "R4 set low");
        step(0,0,0,1, 1,1,8'hFC,0,2'b00,8'h01,0,5'h0A, "R2 no lane");
        step(0,0,0,1, 1,1,8'hF0,1,2'b00,8'h01,0,5'h0A, "R2 bad addr");
        step(0,0,0,1, 1,1,8'hFC,1,2'b01,8'h00,3'd3,5'h0A, "R3 bitpos3");
        step(0,0,0,1, 1,1,8'hFC,1,2'b01,8'h00,3'd0,5'h0A, "R3 bset");
        step(0,0,0,0, 1,1,8'hFC,1,2'b00,8'hFF,0,5'h1B, "R9 port ignored");
        step(0,0,0,0, 1,1,8'hFC,1,2'b10,8'h00,3'd0,5'h1B, "R4 clear low");
        step(0,1,1,0, 1,1,8'hFC,1,2'b00,8'h00,0,5'h03, "R6 ext over other");
        step(0,0,1,1, 1,1,8'hFC,1,2'b00,8'h00,0,5'h03, "R7 R8 other hold");
        step(1,1,1,1, 1,1,8'hFC,1,2'b00,8'h01,0,5'h03, "R5 por priority");
        step(0,0,1,1, 1,1,8'hFC,1,2'b01,8'h00,0,5'h03, "R8 other blocks set");
        step(0,0,0,1, 1,1,8'hFC,1,2'b00,8'hFE,0,5'h03, "R2 byte zero");
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 32) == 0, ($urandom % 32) == 0, ($urandom % 16) == 0,
                 1'($urandom), ($urandom % 4) != 0, 1'($urandom),
                 ($urandom % 4) != 0 ? 8'hFC : 8'($urandom), ($urandom % 8) != 0,
                 2'($urandom), 8'($urandom),
                 ($urandom % 2) != 0 ? 3'd0 : 3'($urandom), 5'($urandom), "rand");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule